// File: doc/BRIEF.md
# Serial EEPROM Single-Word Write Controller

This block sits behind one 32-bit control register and stores a single 16-bit word into an external SPI-style serial EEPROM. Software issues one register write that carries the data word in the upper half, a 14-bit word address below it, and a start flag in bit 0. The block freezes the address and data, clears its completion flag, and runs the device protocol without further software help. It first sends an enable-write command, then the program command with address and data, and then polls the device status until the device stops reporting busy. At that point the completion flag is set again.

No read of the memory contents comes before the write, so a blank or corrupted device can still be written. A start request made while a write is still running is dropped as a whole. Software therefore polls the completion flag before it issues the next word. The serial clock comes from the system clock through a divider whose ratio is a parameter. Chip select returns high between any two commands.

Top module: `nvm_word_writer`

## Requirements
- R1: Out of reset the register reads 0x00000002 (completion flag bit 1 set, all else zero), chip select is high and the serial clock is low.
- R2: A register write with bit 0 set while bit 1 reads 1 latches bits 15:2 as the word address and bits 31:16 as the data. The completion flag reads 0 from the next clock on.
- R3: The start flag (bit 0) reads 1 for exactly the one clock after an accepted start and 0 at every other time.
- R4: A register write with bit 0 clear changes no field and causes no serial traffic, whatever it carries in bit 1 and above.
- R5: A start write made while bit 1 reads 0 is dropped: address and data keep their values, and the word it carries is never programmed.
- R6: After an accepted start, and with no read first, the serial frames are, in order: 8 bits of opcode 0x06; then 40 bits of opcode 0x02, a 16-bit address (two zero bits above the 14-bit word address) and the 16 data bits; then one or more 16-bit frames of opcode 0x05, each followed by 8 status bits returned by the device. All frames are sent most significant bit first.
- R7: The serial clock idles low. The output data line changes only while the serial clock is low, the input line is sampled on the rising edge, and every serial clock level (including the first one after chip select falls) lasts exactly CLK_DIV system clocks.
- R8: Chip select goes high after each frame and stays high for at least one system clock, and for CLK_DIV clocks between frames of one write. The serial clock is low whenever chip select is high.
- R9: Polling repeats while status bit 0 (busy) is 1. The completion flag returns to 1 on the same clock edge on which chip select rises after a status frame that reports bit 0 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one clock per write |
| reg_wdata | input | 32 | Register write data: [31:16] data, [15:2] word address, [1] ignored, [0] start |
| reg_rdata | output | 32 | Register image: [31:16] data, [15:2] address, [1] completion flag, [0] start |
| spi_sck | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The assertions assume that the register strobe lasts one clock per write. They also assume that the device answers a status frame within the same chip-select window and eventually reports not busy. Nothing is assumed about when software writes, so the properties on dropped writes must hold even when a start arrives in the middle of a transfer. The stimulus drives single-clock strobes away from the clock edge. It puts a behavioural device on the serial lines that changes its reply only after falling serial edges, and it sets the number of busy replies per write to 0, 1, 2 or 3 so that every write terminates. It also sends one start deliberately during a busy transfer and one on the clock right after completion.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;
  localparam int ADDR_W     = 14;
  localparam int DATA_W     = 16;
  localparam int OP_W       = 8;
  localparam int SPI_ADDR_W = 16;
  localparam int STAT_W     = 8;
  localparam int FRAME_W    = OP_W + SPI_ADDR_W + DATA_W;
  localparam int LEN_W      = $clog2(FRAME_W + 1);

  localparam logic [OP_W-1:0] OP_WR_ENABLE = 8'h06;
  localparam logic [OP_W-1:0] OP_PROGRAM   = 8'h02;
  localparam logic [OP_W-1:0] OP_STATUS    = 8'h05;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ENABLE,
    SQ_GAP_PROG,
    SQ_PROG,
    SQ_GAP_POLL,
    SQ_POLL
  } seq_state_e;
endpackage

// File: rtl/nvmw_tick.sv
module nvmw_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CNT_W'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nvmw_shift.sv
module nvmw_shift
  import nvmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               launch,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               miso,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  output logic               fin,
  output logic               last_bit
);
  logic               act_q, act_d;
  logic               sck_q, sck_d;
  logic               cs_q, cs_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               smp_q, smp_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    cs_d   = cs_q;
    tx_d   = tx_q;
    left_d = left_q;
    smp_d  = smp_q;
    fin    = 1'b0;
    if (launch) begin
      act_d  = 1'b1;
      cs_d   = 1'b0;
      sck_d  = 1'b0;
      tx_d   = frame;
      left_d = len - LEN_W'(1);
    end else if (act_q && tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        smp_d = miso;
      end else begin
        sck_d = 1'b0;
        if (left_q == '0) begin
          act_d = 1'b0;
          cs_d  = 1'b1;
          fin   = 1'b1;
        end else begin
          tx_d   = tx_q << 1;
          left_d = left_q - LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      tx_q   <= '0;
      left_q <= '0;
      smp_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
      tx_q   <= tx_d;
      left_q <= left_d;
      smp_q  <= smp_d;
    end
  end

  assign sck      = sck_q;
  assign cs_n     = cs_q;
  assign mosi     = tx_q[FRAME_W-1];
  assign last_bit = smp_q;
endmodule

// File: rtl/nvmw_seq.sv
module nvmw_seq
  import nvmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               tick,
  input  logic               fin,
  input  logic               busy,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic               launch,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               tick_en,
  output logic               complete
);
  seq_state_e st_q, st_d;

  logic [FRAME_W-1:0] f_enable, f_prog, f_status;
  assign f_enable = {OP_WR_ENABLE, {(FRAME_W-OP_W){1'b0}}};
  assign f_prog   = {OP_PROGRAM, {(SPI_ADDR_W-ADDR_W){1'b0}}, addr, data};
  assign f_status = {OP_STATUS, {(FRAME_W-OP_W){1'b0}}};

  always_comb begin
    st_d     = st_q;
    launch   = 1'b0;
    frame    = f_enable;
    len      = LEN_W'(OP_W);
    complete = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (go) begin
        launch = 1'b1;
        st_d   = SQ_ENABLE;
      end
      SQ_ENABLE: if (fin) st_d = SQ_GAP_PROG;
      SQ_GAP_PROG: if (tick) begin
        launch = 1'b1;
        frame  = f_prog;
        len    = LEN_W'(FRAME_W);
        st_d   = SQ_PROG;
      end
      SQ_PROG: if (fin) st_d = SQ_GAP_POLL;
      SQ_GAP_POLL: if (tick) begin
        launch = 1'b1;
        frame  = f_status;
        len    = LEN_W'(OP_W + STAT_W);
        st_d   = SQ_POLL;
      end
      SQ_POLL: if (fin) begin
        if (busy) st_d = SQ_GAP_POLL;
        else begin
          st_d     = SQ_IDLE;
          complete = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  assign tick_en = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/nvm_word_writer.sv
module nvm_word_writer
  import nvmw_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              start_q, start_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept, complete, unused_wdata;

  assign unused_wdata = reg_wdata[1];
  assign accept       = reg_wr_en && reg_wdata[0] && done_q;

  always_comb begin
    start_d = accept;
    done_d  = done_q;
    addr_d  = addr_q;
    data_d  = data_q;
    if (accept) begin
      done_d = 1'b0;
      addr_d = reg_wdata[2 +: ADDR_W];
      data_d = reg_wdata[31 -: DATA_W];
    end else if (complete) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b1;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign reg_rdata = {data_q, addr_q, done_q, start_q};

  logic               tick, tick_en, launch, fin, last_bit;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;

  nvmw_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .en(tick_en), .tick(tick)
  );

  nvmw_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .go(start_q), .tick(tick), .fin(fin),
    .busy(last_bit), .addr(addr_q), .data(data_q), .launch(launch),
    .frame(frame), .len(len), .tick_en(tick_en), .complete(complete)
  );

  nvmw_shift u_shift (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .launch(launch),
    .frame(frame), .len(len), .miso(spi_miso), .sck(spi_sck),
    .cs_n(spi_cs_n), .mosi(spi_mosi), .fin(fin), .last_bit(last_bit)
  );
endmodule

// File: rtl/nvmw_checker.sv
module nvmw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_any,
  input logic        wr_start,
  input logic [31:0] image,
  input logic        sck,
  input logic        cs_n,
  input logic        mosi
);
  // R2: an accepted start clears the completion flag
  p_done_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && image[1]) |=> !image[1]);

  // R3: the start flag is a single-clock pulse, only while busy
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    image[0] |=> !image[0]);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    image[0] |-> !image[1]);

  // R4: writes without start leave the fields untouched
  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !wr_start) |=> $stable(image[31:2]));

  // R5: fields are frozen during a write
  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!image[1] && !$past(image[1])) |-> $stable(image[31:2]));

  // R7: data line moves only while the serial clock is low
  p_mosi_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck);

  // R8: idle bus has a low clock; chip select stays high at least a clock
  p_idle_sck_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  // R9: completion coincides with the end of a frame
  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(image[1]) |-> $rose(cs_n));
endmodule

bind nvm_word_writer nvmw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_any(reg_wr_en),
  .wr_start(reg_wr_en && reg_wdata[0]), .image(reg_rdata),
  .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
);

// File: tb/nvm_word_writer_test.sv
`timescale 1ns/100ps
module nvm_word_writer_test;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        miso = 1'b0;
  wire  [31:0] rdata;
  wire         sck, cs_n, mosi;

  always #2.5 clk = ~clk;

  nvm_word_writer #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wdata(wdata),
    .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  int compared = 0, mismatched = 0, cyc = 0, cs_falls = 0;
  bit summary_done = 0;
  string cur_tag = "R1 reset image";

  // expected register image
  logic [13:0] e_addr = '0;
  logic [15:0] e_data = '0;
  bit          e_done = 1, e_start = 0;

  // behavioural device
  bit          wel = 0, prev_sck = 0, prev_cs = 1;
  int          busy_cnt = 0, polls = 0, bitcnt = 0, last_evt = 0, phase = 0;
  logic [39:0] shreg = '0;
  logic [7:0]  stat = '0;
  logic [15:0] mem [int];

  task automatic check(input bit ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
    $finish;
  endtask

  task automatic decode_frame();
    case (phase)
      1: begin
        check(bitcnt == 8, "R6 enable frame length", 40'(bitcnt), 40'd8);
        check(shreg[7:0] == 8'h06, "R6 enable opcode", 40'(shreg[7:0]), 40'h06);
        wel = 1; phase = 2;
      end
      2: begin
        check(bitcnt == 40, "R6 program frame length", 40'(bitcnt), 40'd40);
        check(shreg == {8'h02, 2'b00, e_addr, e_data}, "R6 program frame",
              shreg, {8'h02, 2'b00, e_addr, e_data});
        if (wel) mem[int'(shreg[29:16])] = shreg[15:0];
        busy_cnt = polls; wel = 0; phase = 3;
      end
      3: begin
        check(bitcnt == 16, "R9 status frame length", 40'(bitcnt), 40'd16);
        check(shreg[15:8] == 8'h05, "R9 status opcode", 40'(shreg[15:8]), 40'h05);
        if (stat[0]) busy_cnt--;
        else begin e_done = 1; phase = 0; end
      end
      default: check(0, "R4 unexpected frame", shreg, 40'h0);
    endcase
  endtask

  // reference model, evaluated just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (cyc > 150000) begin
      check(0, "R9 watchdog expired", 40'(cyc), 40'd150000);
      finish_run();
    end
    if (rst_n) begin
      if (wr_en && wdata[0] && e_done) begin
        e_addr = wdata[15:2]; e_data = wdata[31:16];
        e_done = 0; e_start = 1; phase = 1;
      end else e_start = 0;
      if (prev_cs && !cs_n) begin
        cs_falls++; bitcnt = 0; shreg = '0; last_evt = cyc;
        stat = {6'b0, wel, busy_cnt > 0};
      end
      if (sck != prev_sck) begin
        check(cyc - last_evt == DIV, "R7 serial clock level length",
              40'(cyc - last_evt), 40'(DIV));
        last_evt = cyc;
        if (sck && !cs_n) begin shreg = {shreg[38:0], mosi}; bitcnt++; end
      end
      if (!prev_cs && cs_n) decode_frame();
      miso = (!cs_n && bitcnt >= 8 && bitcnt < 16) ? stat[15 - bitcnt] : 1'b0;
      prev_sck = sck; prev_cs = cs_n;
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!summary_done) begin
      check(rdata === {e_data, e_addr, e_done, e_start}, cur_tag,
            40'(rdata), 40'({e_data, e_addr, e_done, e_start}));
      if (cs_n) check(sck == 1'b0, "R8 clock low while deselected", 40'(sck), 40'h0);
    end
  end

  task automatic reg_write(input logic [31:0] v);
    wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !rdata[1]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0, "R1 bus idle in reset",
          40'({cs_n, sck}), 40'b10);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_tag = "R4 write without start";
    reg_write({16'hA5A5, 14'h0155, 1'b0, 1'b0});
    reg_write({16'h5A5A, 14'h2AAA, 1'b1, 1'b0});
    repeat (12) @(negedge clk);
    check(cs_falls == 0, "R4 no serial traffic", 40'(cs_falls), 40'h0);

    polls = 2;
    cur_tag = "R2 R3 accepted start image";
    reg_write({16'hBEEF, 14'h1234, 1'b0, 1'b1});
    repeat (20) @(negedge clk);
    cur_tag = "R5 start while busy";
    reg_write({16'h1111, 14'h0AAA, 1'b1, 1'b1});
    cur_tag = "R9 completion after two busy polls";
    wait_done();
    check(mem.exists(int'(14'h1234)) && mem[int'(14'h1234)] == 16'hBEEF,
          "R6 word stored", 40'(mem[int'(14'h1234)]), 40'hBEEF);
    check(!mem.exists(int'(14'h0AAA)), "R5 dropped word not stored", 40'h1, 40'h0);

    polls = 0;
    cur_tag = "R9 completion on first poll";
    reg_write({16'hFFFF, 14'h3FFF, 1'b0, 1'b1});
    wait_done();
    check(mem[int'(14'h3FFF)] == 16'hFFFF, "R6 top address stored",
          40'(mem[int'(14'h3FFF)]), 40'hFFFF);

    polls = 3;
    cur_tag = "R2 address zero";
    reg_write({16'h0001, 14'h0000, 1'b0, 1'b1});
    wait_done();
    check(mem[0] == 16'h0001, "R6 address zero stored", 40'(mem[0]), 40'h1);

    polls = 1;
    cur_tag = "R2 back-to-back start";
    reg_write({16'h8001, 14'h2001, 1'b0, 1'b1});
    wait_done();
    reg_write({16'h7FFE, 14'h1FFE, 1'b0, 1'b1});
    wait_done();
    check(mem[int'(14'h2001)] == 16'h8001, "R6 first of pair stored",
          40'(mem[int'(14'h2001)]), 40'h8001);
    check(mem[int'(14'h1FFE)] == 16'h7FFE, "R6 second of pair stored",
          40'(mem[int'(14'h1FFE)]), 40'h7FFE);
    check(rdata[1] == 1'b1, "R9 final completion flag", 40'(rdata[1]), 40'h1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule